// File: doc/BRIEF.md
# Dual-Format Stereo Audio Serial Transmitter

This block turns pairs of parallel 24-bit stereo samples into a one-wire serial stream for an audio link where another device is the timing master. The bit clock and the word-select (left/right) clock arrive as inputs. The block oversamples them with its own system clock and drives only the data line. A static format input chooses one of two framings: I2S, or left-justified. The two framings differ in which word-select level marks the left channel and in whether the first bit of a word is delayed by one bit clock.

Samples come in as a left/right pair through a valid/ready handshake. They land in a one-pair holding buffer, which sits in front of the pair currently on the wire, so the next pair can be delivered while the present one is still shifting. A new pair is moved onto the wire only at the start of a left half-frame. If no new pair has arrived, the last pair is transmitted again. A change of format is held back until the next left-channel boundary, as the new setting defines that boundary.

Top module: `aud_ser_tx`

## Requirements
- R1: `fmt_sel` = 0 selects I2S, where `lrclk` low is the left channel. `fmt_sel` = 1 selects left-justified, where `lrclk` high is the left channel. A half-frame starts at each `lrclk` change that is seen at a `bclk` falling edge.
- R2: Each channel word is WORD_W (24) bits, sent MSB first. In left-justified framing the MSB appears on the same `bclk` falling edge at which `lrclk` changes.
- R3: In I2S framing the MSB appears one `bclk` falling edge after the `lrclk` change. On the transition edge itself the line carries the tail of the previous word (its LSB when the half-frame is exactly 24 bit clocks, otherwise 0).
- R4: `sdata` updates only in the system-clock cycle that follows a detected `bclk` fall. It is constant while `bclk` is high.
- R5: Once the LSB has been sent, `sdata` is 0 for the remaining bit clocks of the half-frame.
- R6: `in_ready` is 1 while the holding buffer is empty. It drops in the cycle after a pair is accepted, and it rises again only after a left-channel boundary has moved that pair onto the wire. Data offered while `in_ready` is 0 is not taken.
- R7: A new pair is captured only at a left-channel boundary. The right half-frame sends the right word of that same pair. If nothing new is waiting, the previous pair is sent again.
- R8: A change on `fmt_sel` takes effect at the first `lrclk` change whose new level means left under the new setting. Until then, every half-frame keeps the old format's timing and word.
- R9: After reset `sdata` is 0 and `in_ready` is 1. The first `lrclk` level seen is only a reference, so no word is sent until `lrclk` changes. The pair on the wire resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples `bclk` and `lrclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock from the link master |
| lrclk | input | 1 | Word-select clock from the link master |
| fmt_sel | input | 1 | 0 = I2S, 1 = left-justified |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding buffer can take a pair |
| in_left | input | WORD_W | Left sample |
| in_right | input | WORD_W | Right sample |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench drives the bit clocks itself and captures one bit per `bclk` rising edge. It then compares whole half-frames against words it builds from the requirements. Three corner cases get the most attention. The first is the one-bit I2S delay with 24-clock half-frames: a design that drops the tail would lose each word's LSB, or would put it in the wrong half. The second is a left boundary with no new pair waiting: a broken buffer would send zeros or stale right data instead of repeating the pair. The third is a format change made mid-frame: a design that switched at once would cut a word or shift it by one bit. The bench also offers a second pair while the buffer is full, and it checks that the line does not move while `bclk` is high.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

   typedef enum logic {
      FMT_I2S = 1'b0,
      FMT_LJ  = 1'b1
   } fmt_e;

   // word-select level that opens the left half-frame for a framing
   function automatic logic lvl_is_left(input logic lr, input fmt_e f);
      return (f == FMT_LJ) ? lr : ~lr;
   endfunction

endpackage

// File: rtl/aud_ser_edge.sv
module aud_ser_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic lrclk_i,
   output logic fall_o,
   output logic lr_o
);

   logic bclk_s;
   logic lr_s;
   logic bclk_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign bclk_s = bclk_i;
         assign lr_s   = lrclk_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] b_pipe;
         logic [SYNC_STAGES-1:0] l_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               b_pipe <= '0;
               l_pipe <= '0;
            end else begin
               b_pipe[0] <= bclk_i;
               l_pipe[0] <= lrclk_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  b_pipe[i] <= b_pipe[i-1];
                  l_pipe[i] <= l_pipe[i-1];
               end
            end
         end
         assign bclk_s = b_pipe[SYNC_STAGES-1];
         assign lr_s   = l_pipe[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk_s;
   end

   assign fall_o = bclk_q & ~bclk_s;
   assign lr_o   = lr_s;

endmodule

// File: rtl/aud_ser_pair_buf.sv
module aud_ser_pair_buf #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_left,
   input  logic [W-1:0] in_right,
   input  logic         take_i,
   output logic [W-1:0] up_l_o,
   output logic [W-1:0] cur_r_o
);

   logic [W-1:0] hold_l, hold_r;
   logic [W-1:0] frm_l,  frm_r;
   logic         hold_full;
   logic         accept;

   assign in_ready = ~hold_full;
   assign accept   = in_valid & ~hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l    <= '0;
         hold_r    <= '0;
         frm_l     <= '0;
         frm_r     <= '0;
         hold_full <= 1'b0;
      end else begin
         if (accept) begin
            hold_l    <= in_left;
            hold_r    <= in_right;
            hold_full <= 1'b1;
         end else if (take_i && hold_full) begin
            frm_l     <= hold_l;
            frm_r     <= hold_r;
            hold_full <= 1'b0;
         end
      end
   end

   // the left word a boundary would send right now
   assign up_l_o  = hold_full ? hold_l : frm_l;
   assign cur_r_o = frm_r;

endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift
   import aud_ser_pkg::*;
#(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fall_i,
   input  logic         lr_i,
   input  logic         fmt_i,
   input  logic [W-1:0] up_l_i,
   input  logic [W-1:0] cur_r_i,
   output logic         take_o,
   output logic         fmt_act_o,
   output logic         sdata_o
);

   localparam int CW = $clog2(W + 1);

   logic          lr_last, lr_seen, pend;
   fmt_e          fmt_act, fmt_use, fmt_new;
   logic [W-1:0]  sh, nxt, word_sel;
   logic [CW-1:0] rem;
   logic          lr_flip, left_b, start_lj, start_i2s;

   always_comb begin
      fmt_new   = fmt_e'(fmt_i);
      lr_flip   = fall_i && lr_seen && (lr_i != lr_last);
      left_b    = lr_flip && lvl_is_left(lr_i, fmt_new);
      fmt_use   = left_b ? fmt_new : fmt_act;
      word_sel  = left_b ? up_l_i : cur_r_i;
      start_lj  = lr_flip && (fmt_use == FMT_LJ);
      start_i2s = lr_flip && (fmt_use == FMT_I2S);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_last <= 1'b0;
         lr_seen <= 1'b0;
         pend    <= 1'b0;
         fmt_act <= FMT_I2S;
         sh      <= '0;
         nxt     <= '0;
         rem     <= '0;
         sdata_o <= 1'b0;
      end else if (fall_i) begin
         lr_last <= lr_i;
         lr_seen <= 1'b1;
         pend    <= start_i2s;
         if (start_i2s) nxt <= word_sel;
         if (left_b)    fmt_act <= fmt_new;
         if (start_lj) begin
            sdata_o <= word_sel[W-1];
            sh      <= word_sel << 1;
            rem     <= CW'(W - 1);
         end else if (pend && !lr_flip) begin
            sdata_o <= nxt[W-1];
            sh      <= nxt << 1;
            rem     <= CW'(W - 1);
         end else if (rem != '0) begin
            sdata_o <= sh[W-1];
            sh      <= sh << 1;
            rem     <= rem - 1'b1;
         end else begin
            sdata_o <= 1'b0;
         end
      end
   end

   assign take_o    = left_b;
   assign fmt_act_o = fmt_act;

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
   parameter int WORD_W      = 24,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              lrclk,
   input  logic              fmt_sel,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_left,
   input  logic [WORD_W-1:0] in_right,
   output logic              sdata
);

   generate
      if (WORD_W < 2 || WORD_W > 32) begin : g_bad_word
         $error("aud_ser_tx: WORD_W must lie in 2..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("aud_ser_tx: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              fall, lr_s, take, fmt_act;
   logic [WORD_W-1:0] up_l, cur_r;

   aud_ser_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk),
      .fall_o(fall), .lr_o(lr_s)
   );

   aud_ser_pair_buf #(.W(WORD_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_left(in_left), .in_right(in_right), .take_i(take),
      .up_l_o(up_l), .cur_r_o(cur_r)
   );

   aud_ser_shift #(.W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .fall_i(fall), .lr_i(lr_s), .fmt_i(fmt_sel),
      .up_l_i(up_l), .cur_r_i(cur_r), .take_o(take), .fmt_act_o(fmt_act),
      .sdata_o(sdata)
   );

endmodule

// File: rtl/aud_ser_chk.sv
module aud_ser_chk #(
   parameter int W = 24
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bclk,
   input logic         in_valid,
   input logic         in_ready,
   input logic         sdata,
   input logic         take,
   input logic         fmt_sel,
   input logic         fmt_act,
   input logic [W-1:0] up_l
);

   // R4: the line moves only while the bit clock is low
   p_sdata_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata) |-> !bclk);

   // R6: an accepted pair fills the buffer
   p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R6: the buffer empties only through a left boundary
   p_ready_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(take));

   // R8: the format in force moves only at a left boundary
   p_fmt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fmt_act) |-> $past(take));

   // R2: left-justified left boundary puts the MSB out at once
   p_lj_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && fmt_sel) |=> (sdata == $past(up_l[W-1])));

endmodule

bind aud_ser_tx aud_ser_chk #(.W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bclk(bclk), .in_valid(in_valid),
   .in_ready(in_ready), .sdata(sdata), .take(take), .fmt_sel(fmt_sel),
   .fmt_act(fmt_act), .up_l(up_l)
);

// File: tb/test_aud_ser_tx.sv
module test_aud_ser_tx;

   localparam int W = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bclk = 1'b1;
   logic         lrclk = 1'b0;
   logic         fmt_sel = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [W-1:0] in_left = '0;
   logic [W-1:0] in_right = '0;
   logic         sdata;

   int total = 0;
   int bad   = 0;

   localparam logic [W-1:0] AL = 24'hA5C3F1, AR = 24'h3C0FF0;
   localparam logic [W-1:0] BL = 24'h123457, BR = 24'hFEDCBA;
   localparam logic [W-1:0] CL = 24'h9E3779, CR = 24'h5A5A5B;
   localparam logic [W-1:0] DL = 24'h0F0F0F, DR = 24'hF0F0F0;

   always #2.5 clk = ~clk;

   aud_ser_tx #(.WORD_W(W)) i_aud_ser_tx (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .fmt_sel(fmt_sel),
      .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
      .in_right(in_right), .sdata(sdata)
   );

   task automatic chk(input logic ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] lj_exp(input logic [W-1:0] w);
      logic [63:0] e = '0;
      for (int i = 0; i < W; i++) e[i] = w[W-1-i];
      return e;
   endfunction

   function automatic logic [63:0] i2s_exp(input logic tail, input logic [W-1:0] w,
                                           input int n);
      logic [63:0] e = '0;
      e[0] = tail;
      for (int i = 1; i <= W; i++) if (i < n) e[i] = w[W-i];
      return e;
   endfunction

   // one half-frame: lrclk set with the first falling edge, one bit caught per rising edge
   task automatic run_half(input logic lvl, input int n, input logic [63:0] exp,
                           input string tag);
      logic [63:0] cap = '0;
      logic [63:0] msk = '0;
      logic        moved = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bclk = 1'b0;
         if (i == 0) lrclk = lvl;
         repeat (3) @(negedge clk);
         cap[i] = sdata;
         msk[i] = 1'b1;
         @(negedge clk);
         bclk = 1'b1;
         repeat (3) @(negedge clk);
         if (sdata !== cap[i]) moved = 1'b1;
      end
      chk((cap & msk) === (exp & msk), tag, cap & msk, exp & msk);
      chk(!moved, "R4 line moved while bclk high", {63'd0, moved}, 64'd0);
   endtask

   task automatic push(input logic [W-1:0] l, input logic [W-1:0] r, input string tag);
      @(negedge clk);
      chk(in_ready === 1'b1, {tag, " R6 ready before push"}, {63'd0, in_ready}, 64'd1);
      in_valid = 1'b1; in_left = l; in_right = r;
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready === 1'b0, {tag, " R6 ready after push"}, {63'd0, in_ready}, 64'd0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(sdata === 1'b0, "R9 sdata at reset", {63'd0, sdata}, 64'd0);
      chk(in_ready === 1'b1, "R9 ready at reset", {63'd0, in_ready}, 64'd1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_lj_basic;
      fmt_sel = 1'b1;
      push(AL, AR, "lj");
      run_half(1'b0, 32, 64'd0, "R9 no word before first lrclk change");
      run_half(1'b1, 32, lj_exp(AL), "R1 R2 R5 lj left");
      chk(in_ready === 1'b1, "R6 R7 ready after left boundary", {63'd0, in_ready}, 64'd1);
      run_half(1'b0, 32, lj_exp(AR), "R1 R7 lj right");
   endtask

   task automatic t_repeat;
      run_half(1'b1, 32, lj_exp(AL), "R7 repeat left");
      run_half(1'b0, 32, lj_exp(AR), "R7 repeat right");
   endtask

   task automatic t_fmt_to_i2s;
      fmt_sel = 1'b0;
      push(BL, BR, "i2s");
      // offer another pair while full; it must not be taken
      @(negedge clk);
      in_valid = 1'b1; in_left = DL; in_right = DR;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready === 1'b0, "R6 full buffer stays full", {63'd0, in_ready}, 64'd0);
      run_half(1'b1, 32, lj_exp(AR), "R8 old format kept until left boundary");
      run_half(1'b0, 32, i2s_exp(1'b0, BL, 32), "R1 R3 i2s left delayed MSB");
      run_half(1'b1, 32, i2s_exp(1'b0, BR, 32), "R3 R5 i2s right");
   endtask

   task automatic t_i2s_tight;
      push(CL, CR, "tight");
      run_half(1'b0, 24, i2s_exp(1'b0, CL, 24), "R3 i2s 24-clock left");
      run_half(1'b1, 24, i2s_exp(CL[0], CR, 24), "R3 left LSB on right transition");
      run_half(1'b0, 32, i2s_exp(CR[0], CL, 32), "R3 R7 right LSB then repeated left");
   endtask

   task automatic t_fmt_to_lj;
      fmt_sel = 1'b1;
      run_half(1'b1, 32, lj_exp(CL), "R8 switch to lj at its left boundary");
      run_half(1'b0, 32, lj_exp(CR), "R8 lj right after switch");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_lj_basic();
      t_repeat();
      t_fmt_to_i2s();
      t_i2s_tight();
      t_fmt_to_lj();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule